// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This controller sits between an 8-bit CPU bus and two external memories: a large ROM and a banked RAM. It treats every CPU write into the 32 KB ROM area as a write to one of four control registers. From those registers and the current CPU address it drives the upper ROM address lines, the RAM bank lines, a RAM chip-enable and write strobe, and two general-purpose output pins. The ROM and RAM address outputs follow the CPU address combinationally.

The lower 16 KB ROM window always shows bank 0. The upper 16 KB window shows a switchable bank. A 5-bit bank register supplies the low bank bits, and a bank value of zero is promoted to one. A separate 2-bit register has two meanings, chosen by a one-bit memory model:
- **Large-ROM model (reset default):** the 2-bit register extends the ROM bank to 7 bits.
- **Large-RAM model:** the 2-bit register picks one of four 8 KB RAM banks and also appears on the output pins.

RAM access has to be unlocked by a key value. While RAM is locked, the RAM window reads as 0xFF.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the controller is in the large-ROM model, the 5-bit bank register is 0, the 2-bit register is 0 and RAM is locked. So address 0x4000 maps to ROM byte address 0x04000, ram_ce is 0 and gpo is 0.
- R2: For CPU addresses 0x0000–0x3FFF, rom_addr[20:14] is 0 and rom_addr[13:0] equals cpu_addr[13:0], whatever the register contents.
- R3: A write to 0x2000–0x3FFF loads wdata[4:0] into the low bank register. For CPU addresses 0x4000–0x7FFF, rom_addr[18:14] is that value, or 1 when the value is 0.
- R4: A write to 0x6000–0x7FFF sets the memory model from wdata[0]: 0 selects the large-ROM model and 1 selects the large-RAM model.
- R5: In the large-ROM model, the value written to 0x4000–0x5FFF (wdata[1:0]) drives rom_addr[20:19] in the upper window. In this model ram_addr[14:13] is 0 and gpo is 0.
- R6: In the large-RAM model, wdata[1:0] from the last write to 0x4000–0x5FFF drives ram_addr[14:13] and gpo. In this model rom_addr[20:19] is 0.
- R7: A write to 0x0000–0x1FFF unlocks RAM when wdata[3:0] is 0xA, whatever wdata[7:4] holds. Any other low nibble locks RAM.
- R8: ram_ce is 1 only when RAM is unlocked and cpu_addr is in 0xA000–0xBFFF. For addresses in that range with RAM locked, cpu_rdata is 0xFF.
- R9: A register write takes effect in the cycle after the clock edge that samples cpu_wr. rom_addr, ram_addr, ram_ce and cpu_rdata follow cpu_addr in the same cycle.
- R10: Writes at or above 0x8000 change no register. ram_we is 1 only when ram_ce and cpu_wr are both 1.
- R11: cpu_rdata returns rom_rdata for addresses below 0x8000. It returns ram_rdata in the RAM window when RAM is unlocked, and 0xFF for every other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| rom_rdata | input | 8 | Data from the external ROM |
| ram_rdata | input | 8 | Data from the external RAM |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | 21 | ROM byte address: 7-bit bank and 14-bit offset |
| rom_ce | output | 1 | ROM select, high for addresses below 0x8000 |
| ram_addr | output | 15 | RAM byte address: 2-bit bank and 13-bit offset |
| ram_ce | output | 1 | RAM chip-enable |
| ram_we | output | 1 | RAM write strobe |
| gpo | output | 2 | General-purpose outputs, active in the large-RAM model |

## Verification
Register writes are due one cycle late. The bench drives each write at a falling edge and changes its reference model only after the next rising edge. For one write it checks explicitly that gpo still holds its old value before that edge and the new value after it. Address-driven results are due in the same cycle: the bench changes cpu_addr at a falling edge and samples every output 2 ns later, well before the next rising edge. In this way each comparison lands inside the cycle in which the result is defined.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
    localparam int LO_W = 5;   // low ROM bank field
    localparam int HI_W = 2;   // shared upper field

    typedef enum logic {
        MODEL_BIG_ROM = 1'b0,
        MODEL_BIG_RAM = 1'b1
    } model_e;

    typedef enum logic [1:0] {
        SLOT_RAM_KEY = 2'd0,
        SLOT_BANK_LO = 2'd1,
        SLOT_BANK_HI = 2'd2,
        SLOT_MODEL   = 2'd3
    } slot_e;

    typedef struct packed {
        logic            ram_on;
        logic [LO_W-1:0] bank_lo;
        logic [HI_W-1:0] bank_hi;
        model_e          model;
    } cbc_state_t;
endpackage

// File: rtl/cbc_regs.sv
module cbc_regs
    import cbc_pkg::*;
#(
    parameter logic [3:0] KEY = 4'hA
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      slot,
    input  logic [LO_W-1:0] wdata,
    output cbc_state_t      state_q
);
    cbc_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            case (slot_e'(slot))
                SLOT_RAM_KEY: state_d.ram_on  = (wdata[3:0] == KEY);
                SLOT_BANK_LO: state_d.bank_lo = wdata;
                SLOT_BANK_HI: state_d.bank_hi = wdata[HI_W-1:0];
                SLOT_MODEL:   state_d.model   = model_e'(wdata[0]);
                default:      state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{ram_on: 1'b0, bank_lo: '0, bank_hi: '0, model: MODEL_BIG_ROM};
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/cbc_rom_map.sv
module cbc_rom_map
    import cbc_pkg::*;
#(
    parameter int WIN_W = 14
) (
    input  cbc_state_t               state,
    input  logic [WIN_W+1:0]         cpu_addr,
    output logic [LO_W+HI_W+WIN_W-1:0] rom_addr,
    output logic                     rom_ce
);
    localparam int BANK_W = LO_W + HI_W;

    logic [LO_W-1:0]   lo_eff;
    logic [HI_W-1:0]   hi_eff;
    logic [BANK_W-1:0] bank;

    always_comb begin
        lo_eff   = (state.bank_lo == '0) ? LO_W'(1) : state.bank_lo;
        hi_eff   = (state.model == MODEL_BIG_ROM) ? state.bank_hi : '0;
        bank     = cpu_addr[WIN_W] ? {hi_eff, lo_eff} : '0;
        rom_addr = {bank, cpu_addr[WIN_W-1:0]};
        rom_ce   = ~cpu_addr[WIN_W+1];
    end
endmodule

// File: rtl/cbc_ram_map.sv
module cbc_ram_map
    import cbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 13
) (
    input  cbc_state_t           state,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic                 cpu_wr,
    output logic [HI_W+WIN_W-1:0] ram_addr,
    output logic                 ram_sel,
    output logic                 ram_ce,
    output logic                 ram_we,
    output logic [HI_W-1:0]      gpo
);
    localparam int TAG_W = ADDR_W - WIN_W;
    localparam logic [TAG_W-1:0] RAM_TAG = TAG_W'(5);   // 0xA000 >> 13

    logic [HI_W-1:0] bank;

    always_comb begin
        bank     = (state.model == MODEL_BIG_RAM) ? state.bank_hi : '0;
        ram_sel  = (cpu_addr[ADDR_W-1:WIN_W] == RAM_TAG);
        ram_ce   = ram_sel & state.ram_on;
        ram_we   = ram_ce & cpu_wr;
        ram_addr = {bank, cpu_addr[WIN_W-1:0]};
        gpo      = bank;
    end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int ROM_WIN_W = 14,
    parameter int RAM_WIN_W = 13,
    parameter int DATA_W    = 8,
    localparam int ADDR_W    = ROM_WIN_W + 2,
    localparam int ROM_AW    = LO_W + HI_W + ROM_WIN_W,
    localparam int RAM_AW    = HI_W + RAM_WIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_ce,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_ce,
    output logic              ram_we,
    output logic [HI_W-1:0]   gpo
);
    cbc_state_t state_q;
    logic       reg_wr;
    logic       ram_sel;

    assign reg_wr = cpu_wr & ~cpu_addr[ADDR_W-1];

    cbc_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .slot    (cpu_addr[ADDR_W-2:ADDR_W-3]),
        .wdata   (cpu_wdata[LO_W-1:0]),
        .state_q (state_q)
    );

    cbc_rom_map #(.WIN_W(ROM_WIN_W)) u_rom (
        .state    (state_q),
        .cpu_addr (cpu_addr),
        .rom_addr (rom_addr),
        .rom_ce   (rom_ce)
    );

    cbc_ram_map #(.ADDR_W(ADDR_W), .WIN_W(RAM_WIN_W)) u_ram (
        .state    (state_q),
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .ram_addr (ram_addr),
        .ram_sel  (ram_sel),
        .ram_ce   (ram_ce),
        .ram_we   (ram_we),
        .gpo      (gpo)
    );

    always_comb begin
        if (rom_ce)      cpu_rdata = rom_rdata;
        else if (ram_ce) cpu_rdata = ram_rdata;
        else             cpu_rdata = '1;
    end
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_wr,
    input logic [7:0]  cpu_rdata,
    input logic [20:0] rom_addr,
    input logic [14:0] ram_addr,
    input logic        ram_ce,
    input logic        ram_we,
    input logic [1:0]  gpo
);
    AST_LOW_WINDOW_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00) |-> (rom_addr[20:14] == 7'd0)); // R2
    AST_UPPER_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b01) |-> (rom_addr[18:14] != 5'd0)); // R3
    AST_MODEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_addr[15:14] == 2'b01) && (rom_addr[20:19] != 2'd0)) |-> (gpo == 2'd0)); // R6
    AST_RAM_BANK_MATCHES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce |-> (ram_addr[14:13] == gpo)); // R5
    AST_RAM_CE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce |-> (cpu_addr[15:13] == 3'b101)); // R8
    AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_addr[15:13] == 3'b101) && !ram_ce) |-> (cpu_rdata == 8'hFF)); // R8
    AST_PINS_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(gpo)); // R9
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_ce && cpu_wr)); // R10
endmodule

bind cart_bank_ctrl cbc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_rdata (cpu_rdata),
    .rom_addr  (rom_addr),
    .ram_addr  (ram_addr),
    .ram_ce    (ram_ce),
    .ram_we    (ram_we),
    .gpo       (gpo)
);

// File: tb/cart_bank_ctrl_test.sv
`timescale 1ns/1ps
module cart_bank_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [7:0]  rom_rdata, ram_rdata, cpu_rdata;
    logic [20:0] rom_addr;
    logic [14:0] ram_addr;
    logic        rom_ce, ram_ce, ram_we;
    logic [1:0]  gpo;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model of the register state
    bit       m_on = 1'b0;
    bit [4:0] m_lo = '0;
    bit [1:0] m_hi = '0;
    bit       m_big_ram = 1'b0;

    always #5 clk = ~clk;

    cart_bank_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
        .cpu_rdata(cpu_rdata), .rom_addr(rom_addr), .rom_ce(rom_ce),
        .ram_addr(ram_addr), .ram_ce(ram_ce), .ram_we(ram_we), .gpo(gpo)
    );

    // behavioural memories: data is a function of the address
    function automatic logic [7:0] rom_byte(input logic [20:0] a);
        return a[7:0] ^ {1'b0, a[20:14]};
    endfunction
    function automatic logic [7:0] ram_byte(input logic [14:0] a);
        return a[7:0] ^ {a[14:13], 6'h15};
    endfunction
    assign rom_rdata = rom_byte(rom_addr);
    assign ram_rdata = ram_byte(ram_addr);

    function automatic logic [20:0] exp_rom(input logic [15:0] a);
        logic [6:0] bank;
        bank = 7'd0;
        if (a[14]) bank = {m_big_ram ? 2'b00 : m_hi, (m_lo == 5'd0) ? 5'd1 : m_lo};
        return {bank, a[13:0]};
    endfunction
    function automatic logic [14:0] exp_ram(input logic [15:0] a);
        return {m_big_ram ? m_hi : 2'b00, a[12:0]};
    endfunction
    function automatic logic exp_ce(input logic [15:0] a);
        return (a[15:13] == 3'b101) && m_on;
    endfunction
    function automatic logic [7:0] exp_rd(input logic [15:0] a);
        if (!a[15]) return rom_byte(exp_rom(a));
        if (exp_ce(a)) return ram_byte(exp_ram(a));
        return 8'hFF;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // place an address (no write) and check every output in the same cycle
    task automatic probe(input logic [15:0] a, input string tag);
        @(negedge clk);
        cpu_addr = a;
        cpu_wr = 1'b0;
        #2;
        chk(tag, "rom_addr", 32'(rom_addr), 32'(exp_rom(a)));
        chk(tag, "ram_addr", 32'(ram_addr), 32'(exp_ram(a)));
        chk(tag, "ram_ce", 32'(ram_ce), 32'(exp_ce(a)));
        chk(tag, "gpo", 32'(gpo), 32'(m_big_ram ? m_hi : 2'b00));
        chk(tag, "cpu_rdata", 32'(cpu_rdata), 32'(exp_rd(a)));
        chk(tag, "rom_ce", 32'(rom_ce), 32'(!a[15]));
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (!a[15]) begin
            case (a[14:13])
                2'd0: m_on = (d[3:0] == 4'hA);
                2'd1: m_lo = d[4:0];
                2'd2: m_hi = d[1:0];
                default: m_big_ram = d[0];
            endcase
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_wdata = d;
        cpu_wr = 1'b1;
        #2;
        // R10: the write strobe reaches RAM only when it is selected
        chk("R10", "ram_we", 32'(ram_we), 32'(exp_ce(a)));
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        probe(16'h4000, "R1");
        chk("R1", "rom_addr@4000", 32'(rom_addr), 32'h04000);
        probe(16'hA000, "R1");

        // R3: bank value zero promoted, full-range value
        wr(16'h2000, 8'h00);
        probe(16'h4123, "R3");
        wr(16'h3FFF, 8'hFF);
        probe(16'h7FFF, "R3");
        chk("R3", "bank", 32'(rom_addr[18:14]), 32'h1F);

        // R5: large-ROM model extends the bank
        wr(16'h4000, 8'h02);
        probe(16'h4001, "R5");
        chk("R5", "rom hi", 32'(rom_addr[20:19]), 32'h2);
        probe(16'hA010, "R5");

        // R2: lower window stays bank 0
        probe(16'h0000, "R2");
        probe(16'h3FFF, "R2");

        // R7: key on low nibble only
        wr(16'h0000, 8'h5A);
        probe(16'hA100, "R7");
        chk("R7", "ram_ce unlocked", 32'(ram_ce), 32'h1);
        wr(16'h1FFF, 8'h0B);
        probe(16'hBFFF, "R7");
        chk("R7", "ram_ce locked", 32'(ram_ce), 32'h0);

        // R8: locked window reads 0xFF
        chk("R8", "cpu_rdata", 32'(cpu_rdata), 32'hFF);

        // R4 / R6: switch to large-RAM model
        wr(16'h6000, 8'h01);
        wr(16'h0000, 8'h0A);
        probe(16'hB234, "R6");
        chk("R6", "ram bank", 32'(ram_addr[14:13]), 32'h2);
        probe(16'h5555, "R4");
        chk("R4", "rom hi forced", 32'(rom_addr[20:19]), 32'h0);

        // R9: a write shows only after the sampling edge
        @(negedge clk);
        cpu_addr = 16'h5000;
        cpu_wdata = 8'h01;
        cpu_wr = 1'b1;
        #2;
        chk("R9", "gpo before edge", 32'(gpo), 32'h2);
        @(posedge clk);
        model_write(16'h5000, 8'h01);
        #2;
        chk("R9", "gpo after edge", 32'(gpo), 32'h1);
        @(negedge clk);
        cpu_wr = 1'b0;

        // R10: writes above 0x8000 leave registers alone
        wr(16'hA000, 8'h00);
        wr(16'h8000, 8'h00);
        wr(16'hC000, 8'h0A);
        probe(16'h4000, "R10");
        probe(16'hA000, "R10");

        // R11: reads outside ROM and RAM windows
        probe(16'hC000, "R11");
        probe(16'hFFFF, "R11");

        // R4: back to the large-ROM model
        wr(16'h7000, 8'hFE);
        probe(16'h6000, "R4");

        // random mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom);
            d = 8'($urandom);
            if ($urandom % 4 == 0) d[3:0] = 4'hA;
            if ($urandom % 2 == 0) wr(a, d);
            else probe(a, "R11");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule